// File: doc/BRIEF.md
# I2C Byte FIFO Pair with Threshold Interrupts

This block holds two byte queues that sit between a register interface and an I2C bus engine. Software fills the transmit queue and the engine drains it one byte per bus byte; the engine fills the receive queue and software drains it. Each queue reports its fill count together with full and empty flags. A programmable trigger per direction raises a live "refill" or "drain" request. Pushes into a full queue and pops from an empty one are caught and latched as error flags. A trailing-data timer flags received bytes that have been left waiting while no traffic moves.

All four byte paths use a valid/ready handshake. A byte moves in a cycle where both valid and ready are high. Ready on an input side means the queue is enabled and not full. Valid on an output side means the queue is enabled and not empty. A source does not have to wait for ready. A push attempt made while the queue is full is not stalled: it is dropped and counted as an overrun. In the same way, a pop request made while the queue is empty returns zero and is counted as an underrun. Configuration, status and interrupt pins are plain levels.

The interrupt status vector uses fixed bit positions so that a register wrapper can map it directly. Bit 0 is transmit almost-empty and bit 1 is receive almost-full; these two are live conditions. Bit 2 is transmit underrun, bit 3 transmit overrun, bit 4 receive underrun, bit 5 receive overrun and bit 6 receive trailing; these five are sticky and are cleared by writing one.

Top module: `i2c_byte_fifos`

## Requirements
- R1: After reset both queues are empty with level 0, the empty flags are high, the full flags are low, sticky status bits 2 to 6 are 0 and `irq` is low.
- R2: Bytes leave each queue in the order they were accepted. The level counts the bytes held. Full is high exactly when the level equals DEPTH and empty is high exactly when the level is 0. Input ready is high when the queue is enabled and not full; output valid is high when the queue is enabled and not empty.
- R3: When input valid is high on an enabled, full queue, the byte is dropped, the level is unchanged, and the overrun bit is set (bit 3 for transmit, bit 5 for receive).
- R4: When output ready is high on an enabled, empty queue, the output data reads 0 and the underrun bit is set (bit 2 for transmit, bit 4 for receive).
- R5: Status bit 0 is high while the transmit queue is enabled and its level is at or below `tx_trig`.
- R6: Status bit 1 is high while the receive queue is enabled and its level is at or above `rx_trig`.
- R7: Status bit 6 is set once the receive queue has been non-empty with no receive push and no receive pop for `trail_limit` consecutive clock edges. A `trail_limit` of 0 never sets it.
- R8: Every receive push and every receive pop restarts the trailing count. An emptied receive queue holds the count at zero.
- R9: A 1 in `stat_clr` clears the matching sticky bit (2 to 6) at the next edge, except that a set event in the same cycle wins. `stat_clr` has no effect on the live bits 0 and 1.
- R10: `irq` is high exactly when some status bit and its matching `irq_en` bit are both high.
- R11: A queue whose enable is low is flushed to empty, holds input ready and output valid low, and ignores push and pop attempts without setting any error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit queue enable |
| rx_en | input | 1 | Receive queue enable |
| tx_trig | input | LVL_W | Transmit almost-empty trigger level |
| rx_trig | input | LVL_W | Receive almost-full trigger level |
| trail_limit | input | TRAIL_W | Idle edges before the trailing flag is set |
| irq_en | input | 7 | Per-bit interrupt enable |
| stat_clr | input | 7 | Write-one-to-clear strobe for the sticky bits |
| sw_tx_valid | input | 1 | Software offers a transmit byte |
| sw_tx_ready | output | 1 | Transmit queue accepts a byte |
| sw_tx_data | input | 8 | Transmit byte from software |
| eng_tx_valid | output | 1 | Transmit byte available to the engine |
| eng_tx_ready | input | 1 | Engine takes a transmit byte |
| eng_tx_data | output | 8 | Transmit byte to the engine (0 when empty) |
| eng_rx_valid | input | 1 | Engine offers a received byte |
| eng_rx_ready | output | 1 | Receive queue accepts a byte |
| eng_rx_data | input | 8 | Received byte from the engine |
| sw_rx_valid | output | 1 | Received byte available to software |
| sw_rx_ready | input | 1 | Software takes a received byte |
| sw_rx_data | output | 8 | Received byte to software (0 when empty) |
| tx_level | output | LVL_W | Bytes held in the transmit queue |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_level | output | LVL_W | Bytes held in the receive queue |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| irq_stat | output | 7 | Interrupt status vector |
| irq | output | 1 | Combined interrupt request |

## Verification
The trailing flag is the hardest behaviour to reach from the ports. It depends on the exact number of idle edges after the last receive push or pop, and every push or pop restarts that count. The stimulus therefore places receive pushes and pops at spacings just below the limit and confirms the flag stays low. It then lets exactly `trail_limit` idle edges pass after the last movement and samples on either side of the edge where the flag should rise. A second hard case is a clear and an overrun that land in the same cycle. To produce it, the transmit queue is kept full while a push and the clear are presented together.

// File: rtl/i2c_byte_fifos_pkg.sv
package i2c_byte_fifos_pkg;
  localparam int unsigned NUM_STAT   = 7;
  localparam int unsigned ST_TX_AE   = 0;
  localparam int unsigned ST_RX_AF   = 1;
  localparam int unsigned ST_TX_UNF  = 2;
  localparam int unsigned ST_TX_OVF  = 3;
  localparam int unsigned ST_RX_UNF  = 4;
  localparam int unsigned ST_RX_OVF  = 5;
  localparam int unsigned ST_RX_TRL  = 6;
endpackage

// File: rtl/i2cq_byte_queue.sv
module i2cq_byte_queue #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_data,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             push,
  output logic             pop,
  output logic             ovf,
  output logic             unf
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] count;

  assign full      = (count == LVL_W'(DEPTH));
  assign empty     = (count == '0);
  assign level     = count;
  assign in_ready  = en && !full;
  assign out_valid = en && !empty;
  assign push      = in_valid && in_ready;
  assign pop       = out_ready && out_valid;
  assign ovf       = en && in_valid && full;
  assign unf       = en && out_ready && empty;
  assign out_data  = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (!en) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      unique case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/i2cq_trail_timer.sv
module i2cq_trail_timer #(
  parameter int unsigned TRAIL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               restart,
  input  logic [TRAIL_W-1:0] limit,
  output logic               fire
);
  logic [TRAIL_W-1:0] cnt;
  logic               stepping;

  assign stepping = active && !restart && (cnt != limit);
  assign fire     = stepping && (({1'b0, cnt} + 1'b1) == {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!active || restart) cnt <= '0;
    else if (stepping)         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_byte_fifos.sv
module i2c_byte_fifos
  import i2c_byte_fifos_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned TRAIL_W = 4,
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic               rx_en,
  input  logic [LVL_W-1:0]   tx_trig,
  input  logic [LVL_W-1:0]   rx_trig,
  input  logic [TRAIL_W-1:0] trail_limit,
  input  logic [6:0]         irq_en,
  input  logic [6:0]         stat_clr,
  input  logic               sw_tx_valid,
  output logic               sw_tx_ready,
  input  logic [7:0]         sw_tx_data,
  output logic               eng_tx_valid,
  input  logic               eng_tx_ready,
  output logic [7:0]         eng_tx_data,
  input  logic               eng_rx_valid,
  output logic               eng_rx_ready,
  input  logic [7:0]         eng_rx_data,
  output logic               sw_rx_valid,
  input  logic               sw_rx_ready,
  output logic [7:0]         sw_rx_data,
  output logic [LVL_W-1:0]   tx_level,
  output logic               tx_full,
  output logic               tx_empty,
  output logic [LVL_W-1:0]   rx_level,
  output logic               rx_full,
  output logic               rx_empty,
  output logic [6:0]         irq_stat,
  output logic               irq
);
  logic tx_push, tx_pop, tx_ovf, tx_unf;
  logic rx_push, rx_pop, rx_ovf, rx_unf;
  logic trail_fire;
  logic [NUM_STAT-1:0] sticky_q, set_vec;

  i2cq_byte_queue #(.DEPTH(DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .en(tx_en),
    .in_valid(sw_tx_valid), .in_ready(sw_tx_ready), .in_data(sw_tx_data),
    .out_valid(eng_tx_valid), .out_ready(eng_tx_ready), .out_data(eng_tx_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty),
    .push(tx_push), .pop(tx_pop), .ovf(tx_ovf), .unf(tx_unf)
  );

  i2cq_byte_queue #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .en(rx_en),
    .in_valid(eng_rx_valid), .in_ready(eng_rx_ready), .in_data(eng_rx_data),
    .out_valid(sw_rx_valid), .out_ready(sw_rx_ready), .out_data(sw_rx_data),
    .level(rx_level), .full(rx_full), .empty(rx_empty),
    .push(rx_push), .pop(rx_pop), .ovf(rx_ovf), .unf(rx_unf)
  );

  i2cq_trail_timer #(.TRAIL_W(TRAIL_W)) u_trail (
    .clk(clk), .rst_n(rst_n),
    .active(rx_en && !rx_empty),
    .restart(rx_push || rx_pop),
    .limit(trail_limit),
    .fire(trail_fire)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[ST_TX_UNF] = tx_unf;
    set_vec[ST_TX_OVF] = tx_ovf;
    set_vec[ST_RX_UNF] = rx_unf;
    set_vec[ST_RX_OVF] = rx_ovf;
    set_vec[ST_RX_TRL] = trail_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= (sticky_q & ~stat_clr) | set_vec;
  end

  always_comb begin
    irq_stat           = sticky_q;
    irq_stat[ST_TX_AE] = tx_en && (tx_level <= tx_trig);
    irq_stat[ST_RX_AF] = rx_en && (rx_level >= rx_trig);
  end

  assign irq = |(irq_stat & irq_en);
endmodule

// File: rtl/i2c_byte_fifos_chk.sv
module i2c_byte_fifos_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             rx_en,
  input logic [6:0]       irq_en,
  input logic [6:0]       stat_clr,
  input logic             sw_tx_valid,
  input logic             sw_tx_ready,
  input logic             eng_tx_valid,
  input logic             eng_tx_ready,
  input logic             eng_rx_valid,
  input logic             sw_rx_ready,
  input logic [LVL_W-1:0] tx_level,
  input logic             tx_full,
  input logic             tx_empty,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_full,
  input logic             rx_empty,
  input logic [6:0]       irq_stat,
  input logic             irq
);
  p_full_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !sw_tx_ready);

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));

  p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_tx_valid && sw_tx_ready && !(eng_tx_valid && eng_tx_ready))
      |=> tx_level == $past(tx_level) + 1'b1);

  p_overrun_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && sw_tx_valid && tx_full) |=> irq_stat[3]);

  p_overrun_keeps_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && sw_tx_valid && tx_full && !(eng_tx_valid && eng_tx_ready))
      |=> tx_level == $past(tx_level));

  p_underrun_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && sw_rx_ready && rx_empty) |=> irq_stat[4]);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr[5] && !(rx_en && eng_rx_valid && rx_full)) |=> !irq_stat[5]);

  p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 7'd0) |-> !irq);

  p_disable_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> tx_empty);
endmodule

bind i2c_byte_fifos i2c_byte_fifos_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
  .irq_en(irq_en), .stat_clr(stat_clr),
  .sw_tx_valid(sw_tx_valid), .sw_tx_ready(sw_tx_ready),
  .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready),
  .eng_rx_valid(eng_rx_valid), .sw_rx_ready(sw_rx_ready),
  .tx_level(tx_level), .tx_full(tx_full), .tx_empty(tx_empty),
  .rx_level(rx_level), .rx_full(rx_full), .rx_empty(rx_empty),
  .irq_stat(irq_stat), .irq(irq)
);

// File: tb/i2c_byte_fifos_bench.sv
module i2c_byte_fifos_bench;
  localparam int unsigned DEPTH   = 16;
  localparam int unsigned TRAIL_W = 4;
  localparam int unsigned LVL_W   = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, rx_en = 1'b0;
  logic [LVL_W-1:0] tx_trig = '0, rx_trig = '0;
  logic [TRAIL_W-1:0] trail_limit = '0;
  logic [6:0] irq_en = '0, stat_clr = '0;
  logic sw_tx_valid = 1'b0, eng_tx_ready = 1'b0, eng_rx_valid = 1'b0, sw_rx_ready = 1'b0;
  logic [7:0] sw_tx_data = '0, eng_rx_data = '0;
  logic sw_tx_ready, eng_tx_valid, eng_rx_ready, sw_rx_valid;
  logic [7:0] eng_tx_data, sw_rx_data;
  logic [LVL_W-1:0] tx_level, rx_level;
  logic tx_full, tx_empty, rx_full, rx_empty, irq;
  logic [6:0] irq_stat;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_byte_fifos #(.DEPTH(DEPTH), .TRAIL_W(TRAIL_W)) u_i2c_byte_fifos (.*);

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push_tx(input logic [7:0] b);
    sw_tx_valid = 1'b1; sw_tx_data = b; tick(); sw_tx_valid = 1'b0;
  endtask

  task automatic pop_tx(output logic [7:0] b);
    eng_tx_ready = 1'b1; #1 b = eng_tx_data; tick(); eng_tx_ready = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    eng_rx_valid = 1'b1; eng_rx_data = b; tick(); eng_rx_valid = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] b);
    sw_rx_ready = 1'b1; #1 b = sw_rx_data; tick(); sw_rx_ready = 1'b0;
  endtask

  task automatic clear_all();
    stat_clr = 7'h7C; tick(); stat_clr = '0;
  endtask

  task automatic t_reset();
    chk(tx_level, 0, "R1 tx level");
    chk(rx_level, 0, "R1 rx level");
    chk(tx_empty, 1, "R1 tx empty");
    chk(rx_empty, 1, "R1 rx empty");
    chk(tx_full, 0, "R1 tx full");
    chk(irq_stat[6:2], 0, "R1 sticky bits");
    chk(irq, 0, "R1 irq");
  endtask

  task automatic t_order_overrun();
    logic [7:0] b;
    for (int i = 0; i < DEPTH; i++) push_tx(8'(8'h30 + i));
    chk(tx_level, DEPTH, "R2 level after fill");
    chk(tx_full, 1, "R2 full flag");
    chk(sw_tx_ready, 0, "R2 ready low when full");
    push_tx(8'hEE);
    chk(irq_stat[3], 1, "R3 tx overrun set");
    chk(tx_level, DEPTH, "R3 level unchanged");
    for (int i = 0; i < DEPTH; i++) begin
      pop_tx(b);
      chk(b, 8'h30 + i, "R2 order");
    end
    chk(tx_empty, 1, "R2 empty after drain");
    chk(eng_tx_valid, 0, "R2 valid low when empty");
    clear_all();
  endtask

  task automatic t_underrun();
    logic [7:0] b;
    pop_rx(b);
    chk(b, 0, "R4 empty read data");
    chk(irq_stat[4], 1, "R4 rx underrun set");
    pop_tx(b);
    chk(b, 0, "R4 tx empty data");
    chk(irq_stat[2], 1, "R4 tx underrun set");
    clear_all();
    chk(irq_stat[6:2], 0, "R9 cleared");
  endtask

  task automatic t_thresholds();
    logic [7:0] b;
    tx_trig = 2; rx_trig = 3; #1;
    chk(irq_stat[0], 1, "R5 ae at level 0");
    push_tx(1); push_tx(2);
    chk(irq_stat[0], 1, "R5 ae at trigger");
    push_tx(3);
    chk(irq_stat[0], 0, "R5 ae above trigger");
    push_rx(1); push_rx(2);
    chk(irq_stat[1], 0, "R6 af below trigger");
    push_rx(3);
    chk(irq_stat[1], 1, "R6 af at trigger");
    for (int i = 0; i < 3; i++) pop_tx(b);
    for (int i = 0; i < 3; i++) pop_rx(b);
    chk(rx_empty, 1, "R6 drained");
    rx_trig = 8; clear_all();
  endtask

  task automatic t_trailing();
    logic [7:0] b;
    trail_limit = 5;
    push_rx(8'h5A);
    repeat (4) tick();
    chk(irq_stat[6], 0, "R7 not yet after 4 edges");
    tick();
    chk(irq_stat[6], 1, "R7 set after limit");
    stat_clr = 7'h40; tick(); stat_clr = '0;
    tick();
    chk(irq_stat[6], 0, "R9 trailing cleared, no refire");
    pop_rx(b);
    chk(b, 8'h5A, "R7 byte kept");
    repeat (8) tick();
    chk(irq_stat[6], 0, "R8 empty holds count");
  endtask

  task automatic t_restart();
    logic [7:0] b;
    push_rx(1); repeat (3) tick();
    push_rx(2); repeat (3) tick();
    chk(irq_stat[6], 0, "R8 push restarts");
    pop_rx(b); repeat (3) tick();
    chk(irq_stat[6], 0, "R8 pop restarts");
    repeat (2) tick();
    chk(irq_stat[6], 1, "R8 fires after limit from pop");
    pop_rx(b);
    chk(b, 2, "R8 remaining byte");
    clear_all();
    trail_limit = 0;
    push_rx(9); repeat (20) tick();
    chk(irq_stat[6], 0, "R7 limit zero disabled");
    pop_rx(b);
  endtask

  task automatic t_clear_race_and_mask();
    for (int i = 0; i < DEPTH; i++) push_tx(8'(i));
    push_tx(8'hAA);
    irq_en = 7'h08; #1;
    chk(irq, 1, "R10 enabled bit raises irq");
    irq_en = 7'h10; #1;
    chk(irq, 0, "R10 masked bit");
    irq_en = 7'h00;
    sw_tx_valid = 1'b1; stat_clr = 7'h08; tick();
    sw_tx_valid = 1'b0; stat_clr = '0;
    chk(irq_stat[3], 1, "R9 set wins over clear");
    stat_clr = 7'h01; tx_trig = 16; tick(); stat_clr = '0;
    chk(irq_stat[0], 1, "R9 live bit unaffected");
    tx_trig = 2;
    clear_all();
    chk(irq_stat[3], 0, "R9 overrun cleared");
  endtask

  task automatic t_disable();
    logic [7:0] b;
    tx_en = 1'b0; tick();
    chk(tx_level, 0, "R11 flush on disable");
    chk(sw_tx_ready, 0, "R11 ready low");
    push_tx(8'h11); pop_tx(b);
    chk(irq_stat[3:2], 0, "R11 no flags while disabled");
    chk(irq_stat[0], 0, "R11 ae off when disabled");
    tx_en = 1'b1; tick();
    chk(tx_empty, 1, "R11 empty after re-enable");
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    tx_en = 1'b1; rx_en = 1'b1; rx_trig = 8; tx_trig = 0;
    tick();
    t_order_overrun();
    t_underrun();
    t_thresholds();
    t_trailing();
    t_restart();
    t_clear_race_and_mask();
    t_disable();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule